// File: doc/BRIEF.md
# No-Turnaround Pipelined Synchronous SRAM

This block is a synchronous static memory core for a large chip. Reads and writes share the same two-cycle pipeline, so the data bus can carry a read result or a write operand in every cycle. A command is captured on one rising clock edge. The data phase for that command takes place at the second enabled edge after it. For a read, data appears on the output port after that edge. For a write, data is sampled from the input port on that edge. Because both directions have the same latency, commands can run back to back in any order with no idle bus cycles.

A command is either a load or a continue. A load carries a new address, three chip selects, a read/write flag and per-byte write enables. A continue ignores the address, the selects and the read/write flag. It steps a two-bit burst counter, in either linear or interleaved order, and repeats the operation type of the last load. A clock enable freezes the whole pipeline. An asynchronous output enable gates only the read drive. A sleep request drains the pipeline and silences the block while the array keeps its contents. The bidirectional bus is split into a data-in port, a data-out port and a drive flag.

Top module: `pipe_sram`

## Requirements
- R1: A read load captured at enabled edge k drives the word at its address on `rdata` after enabled edge k+2, with `rdata_oe` high while `oe_n` is low.
- R2: A write load captured at enabled edge k takes its data from `wdata` at enabled edge k+2. Byte lane i (bits 8i+7:8i) is written only when bit i of `be_n` was low at edge k. When a read follows a write to the same address back to back, the read returns the new data.
- R3: A load (`adv` low) is an access only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. It is a read when `rd_wr`=1 and a write when `rd_wr`=0.
- R4: A load with any select inactive is a deselect. It writes nothing, and `rdata_oe` stays low for its data slot.
- R5: A continue (`adv` high) ignores `addr`, the selects and `rd_wr`. It repeats the last load's operation, and it stays a deselect when that load was a deselect. `be_n` is sampled afresh on every write continue.
- R6: The address of a continue keeps the upper bits of the load address. Its two low bits are load_low + n mod 4 when `lin_order`=1, or load_low XOR n when `lin_order`=0, where n counts the continues mod 4. The address therefore returns to the start every fourth continue.
- R7: While `cke_n` is high, no stage advances and no write happens. A read word already driven stays driven and unchanged. A write slot stays undriven.
- R8: A read issued while `oe_n` is high transfers nothing to the bus, and a write with `be_n` all ones changes no byte. Each still uses one pipeline slot.
- R9: `rdata_oe` follows `oe_n` combinationally within a cycle, and it is never high for a write slot.
- R10: From the second edge after `sleep` rises, commands are ignored, pending operations are dropped, `rdata_oe` is low, and array contents are kept.
- R11: After `sleep` falls, commands at the first two edges are still ignored. A command at the third edge is executed normally.
- R12: During and after reset both pipeline stages hold deselects and `rdata_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cke_n | input | 1 | Clock enable, high stalls the pipeline |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| adv | input | 1 | 1 = continue burst, 0 = load new command |
| rd_wr | input | 1 | 1 = read, 0 = write (loads only) |
| addr | input | ADDR_W | Word address (loads only) |
| be_n | input | DATA_W/BYTE_W | Byte write enables, active low |
| lin_order | input | 1 | Burst order: 1 linear, 0 interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Low-power request, active high |
| wdata | input | DATA_W | Write data, sampled two enabled edges after its command |
| rdata | output | DATA_W | Read data |
| rdata_oe | output | 1 | High when `rdata` should drive the shared bus |

## Verification
The bench builds the block with its defaults: 256 words of 32 bits in four byte lanes. At that size every word can be filled by linear bursts and read back by interleaved bursts from all four start offsets, and the wrap on the fifth access of a burst can be seen. Every byte lane can be masked on its own. A compact bench-side array and a two-slot pipeline model, written from the requirements, predict every cycle of directed and random mixes. These mixes cover stalls, deselect bursts, output-enable pulses within a cycle, and the exact edge counts at which sleep entry and exit take effect.

// File: rtl/pipe_sram_pkg.sv
`timescale 1ns/1ps
package pipe_sram_pkg;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;

  // low two address bits of the n-th burst beat
  function automatic logic [1:0] burst_low(input logic [1:0] start,
                                           input logic [1:0] beat,
                                           input logic       linear);
    burst_low = linear ? (start + beat) : (start ^ beat);
  endfunction

endpackage

// File: rtl/psr_rst_sync.sv
`timescale 1ns/1ps
module psr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_o_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_o_n = stage_q[1];
endmodule

// File: rtl/psr_sleep_sync.sv
`timescale 1ns/1ps
module psr_sleep_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep,
  output logic asleep_o
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], sleep};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign asleep_o = sync_q[1];
endmodule

// File: rtl/psr_cmd_decode.sv
`timescale 1ns/1ps
module psr_cmd_decode
  import pipe_sram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic              sel_a_n,
  input  logic              sel_b,
  input  logic              sel_c_n,
  input  logic              adv,
  input  logic              rd_wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic              lin_order,
  output op_e               op_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] base_q, base_d;
  logic [1:0]        beat_q, beat_d;
  op_e               bop_q, bop_d;
  logic              sel_ok;

  assign sel_ok = !sel_a_n && sel_b && !sel_c_n;

  always_comb begin
    base_d = base_q;
    beat_d = beat_q;
    bop_d  = bop_q;
    if (!adv) begin
      op_o   = sel_ok ? (rd_wr ? OP_RD : OP_WR) : OP_IDLE;
      addr_o = addr;
      base_d = addr;
      beat_d = 2'd0;
      bop_d  = op_o;
    end else begin
      beat_d = beat_q + 2'd1;
      op_o   = bop_q;
      addr_o = {base_q[ADDR_W-1:2], burst_low(base_q[1:0], beat_d, lin_order)};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      beat_q <= 2'd0;
      bop_q  <= OP_IDLE;
    end else if (fire) begin
      base_q <= base_d;
      beat_q <= beat_d;
      bop_q  <= bop_d;
    end
  end

  // R5: a continue after a deselect load stays a deselect
  p_cont_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && bop_q == OP_IDLE) |-> (op_o == OP_IDLE));

  // R6: continues keep the burst start address
  p_burst_base_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && adv) |=> $stable(base_q));
endmodule

// File: rtl/psr_array.sv
`timescale 1ns/1ps
module psr_array #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  localparam int NB    = DATA_W / BYTE_W,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NB-1:0]     be_n,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata_o
);
  for (genvar b = 0; b < NB; b++) begin : g_lane
    logic [BYTE_W-1:0] lane_mem [DEPTH];
    logic [BYTE_W-1:0] lane_q;

    always_ff @(posedge clk) begin
      if (we && !be_n[b]) lane_mem[addr] <= wdata[b*BYTE_W +: BYTE_W];
    end

    always_ff @(posedge clk) begin
      if (re) lane_q <= lane_mem[addr];
    end

    assign rdata_o[b*BYTE_W +: BYTE_W] = lane_q;
  end

  // R2: one array access per slot
  p_one_access_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && re));
endmodule

// File: rtl/pipe_sram.sv
`timescale 1ns/1ps
module pipe_sram
  import pipe_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  localparam int NB    = DATA_W / BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke_n,
  input  logic              sel_a_n,
  input  logic              sel_b,
  input  logic              sel_c_n,
  input  logic              adv,
  input  logic              rd_wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NB-1:0]     be_n,
  input  logic              lin_order,
  input  logic              oe_n,
  input  logic              sleep,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_oe
);
  logic rst_i_n, asleep, fire;
  op_e               dec_op;
  logic [ADDR_W-1:0] dec_addr;
  op_e               s1_op_q, s1_op_d, s2_op_q, s2_op_d;
  logic [ADDR_W-1:0] s1_addr_q, s1_addr_d, s2_addr_q, s2_addr_d;
  logic [NB-1:0]     s1_be_q, s1_be_d, s2_be_q, s2_be_d;
  logic              out_rd_q, out_rd_d;
  logic              mem_we, mem_re;

  psr_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_o_n(rst_i_n));

  psr_sleep_sync u_sleep (.clk(clk), .rst_n(rst_i_n), .sleep(sleep), .asleep_o(asleep));

  assign fire = !cke_n && !asleep;

  psr_cmd_decode #(.ADDR_W(ADDR_W)) u_dec (
    .clk(clk), .rst_n(rst_i_n), .fire(fire),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .adv(adv), .rd_wr(rd_wr), .addr(addr), .lin_order(lin_order),
    .op_o(dec_op), .addr_o(dec_addr)
  );

  always_comb begin
    s1_op_d   = s1_op_q;
    s1_addr_d = s1_addr_q;
    s1_be_d   = s1_be_q;
    s2_op_d   = s2_op_q;
    s2_addr_d = s2_addr_q;
    s2_be_d   = s2_be_q;
    out_rd_d  = out_rd_q;
    if (asleep) begin
      s1_op_d  = OP_IDLE;
      s2_op_d  = OP_IDLE;
      out_rd_d = 1'b0;
    end else if (fire) begin
      s2_op_d   = s1_op_q;
      s2_addr_d = s1_addr_q;
      s2_be_d   = s1_be_q;
      s1_op_d   = dec_op;
      s1_addr_d = dec_addr;
      s1_be_d   = be_n;
      out_rd_d  = (s2_op_q == OP_RD);
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      s1_op_q   <= OP_IDLE;
      s1_addr_q <= '0;
      s1_be_q   <= '1;
      s2_op_q   <= OP_IDLE;
      s2_addr_q <= '0;
      s2_be_q   <= '1;
      out_rd_q  <= 1'b0;
    end else begin
      s1_op_q   <= s1_op_d;
      s1_addr_q <= s1_addr_d;
      s1_be_q   <= s1_be_d;
      s2_op_q   <= s2_op_d;
      s2_addr_q <= s2_addr_d;
      s2_be_q   <= s2_be_d;
      out_rd_q  <= out_rd_d;
    end
  end

  assign mem_we = fire && (s2_op_q == OP_WR);
  assign mem_re = fire && (s2_op_q == OP_RD);

  psr_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_array (
    .clk(clk), .rst_n(rst_i_n), .we(mem_we), .re(mem_re),
    .addr(s2_addr_q), .be_n(s2_be_q), .wdata(wdata), .rdata_o(rdata)
  );

  assign rdata_oe = out_rd_q && !oe_n && !asleep;

  // R1: a driven slot always comes from a read in the second stage
  p_rd_source_r1: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(out_rd_q) |-> ($past(s2_op_q) == OP_RD));

  // R7: stall freezes the pipeline and the read word
  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_i_n)
    (cke_n && !asleep) |=> ($stable(s2_op_q) && $stable(s2_addr_q) && $stable(out_rd_q)));

  p_stall_data_r7: assert property (@(posedge clk) disable iff (!rst_i_n)
    (cke_n && !asleep) |=> $stable(rdata));

  // R9: a write slot never drives the bus
  p_wr_quiet_r9: assert property (@(posedge clk) disable iff (!rst_i_n)
    (fire && s2_op_q == OP_WR) |=> !rdata_oe);

  // R10: sleep drains both stages and silences the bus
  p_sleep_drain_r10: assert property (@(posedge clk) disable iff (!rst_i_n)
    asleep |=> (s1_op_q == OP_IDLE && s2_op_q == OP_IDLE));

  p_sleep_quiet_r10: assert property (@(posedge clk) disable iff (!rst_i_n)
    asleep |-> !rdata_oe);
endmodule

// File: tb/pipe_sram_test.sv
`timescale 1ns/1ps
module pipe_sram_test;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam int BW = 8;
  localparam int NB = DW / BW;
  localparam int DEPTH = 1 << AW;

  typedef enum int {K_ID, K_RD, K_WR} kind_e;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, cke_n, sel_a_n, sel_b, sel_c_n, adv, rd_wr, lin_order, oe_n, sleep, rdata_oe;
  logic [AW-1:0] addr;
  logic [NB-1:0] be_n;
  logic [DW-1:0] wdata, rdata;

  pipe_sram #(.ADDR_W(AW), .DATA_W(DW), .BYTE_W(BW)) uut (
    .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .sel_a_n(sel_a_n), .sel_b(sel_b),
    .sel_c_n(sel_c_n), .adv(adv), .rd_wr(rd_wr), .addr(addr), .be_n(be_n),
    .lin_order(lin_order), .oe_n(oe_n), .sleep(sleep), .wdata(wdata),
    .rdata(rdata), .rdata_oe(rdata_oe)
  );

  int n_chk = 0;
  int n_err = 0;

  // bench-side model
  logic [DW-1:0] mref [DEPTH];
  kind_e p1k = K_ID, p2k = K_ID, bk = K_ID;
  logic [AW-1:0] p1a = '0, p2a = '0, bb = '0;
  logic [NB-1:0] p1b = '1, p2b = '1;
  logic [1:0] bc = 2'd0;
  logic m_rd = 1'b0;
  logic [DW-1:0] m_dat = '0;
  logic ms0 = 1'b0, ms1 = 1'b0;
  int dsel_ix = 0;
  logic b_oe_n = 1'b0, b_sleep = 1'b0, b_lin = 1'b1;

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_model(input string tag);
    logic ed;
    ed = m_rd && !oe_n && !ms1;
    chk(tag, {{(DW-1){1'b0}}, rdata_oe}, {{(DW-1){1'b0}}, ed});
    if (ed) chk(tag, rdata, m_dat);
  endtask

  task automatic cyc(input bit ld, input bit act, input bit rd, input logic [AW-1:0] a,
                     input logic [NB-1:0] ben, input bit stall, input string tag);
    logic [DW-1:0] wd;
    kind_e nk;
    logic [AW-1:0] na;
    logic [1:0] lo;
    @(negedge clk);
    check_model(tag);
    wd = $urandom;
    adv = !ld; rd_wr = rd; addr = a; be_n = ben; cke_n = stall; wdata = wd;
    oe_n = b_oe_n; sleep = b_sleep; lin_order = b_lin;
    if (act) {sel_a_n, sel_b, sel_c_n} = 3'b010;
    else begin
      case (dsel_ix)
        0:       {sel_a_n, sel_b, sel_c_n} = 3'b110;
        1:       {sel_a_n, sel_b, sel_c_n} = 3'b000;
        default: {sel_a_n, sel_b, sel_c_n} = 3'b011;
      endcase
      dsel_ix = (dsel_ix + 1) % 3;
    end
    @(posedge clk);
    if (!ms1 && !stall) begin
      if (p2k == K_WR)
        for (int b = 0; b < NB; b++)
          if (!p2b[b]) mref[p2a][b*BW +: BW] = wd[b*BW +: BW];
      m_rd = (p2k == K_RD);
      if (m_rd) m_dat = mref[p2a];
      if (ld) begin
        nk = act ? (rd ? K_RD : K_WR) : K_ID;
        bb = a; bc = 2'd0; bk = nk; na = a;
      end else begin
        bc = bc + 2'd1;
        nk = bk;
        lo = b_lin ? (bb[1:0] + bc) : (bb[1:0] ^ bc);
        na = {bb[AW-1:2], lo};
      end
      p2k = p1k; p2a = p1a; p2b = p1b;
      p1k = nk;  p1a = na;  p1b = ben;
    end else if (ms1) begin
      p1k = K_ID; p2k = K_ID; m_rd = 1'b0;
    end
    ms1 = ms0;
    ms0 = b_sleep;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(1, 0, 0, '0, '1, 0, tag);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; cke_n = 1'b0; {sel_a_n, sel_b, sel_c_n} = 3'b110; adv = 1'b0;
    rd_wr = 1'b1; addr = '0; be_n = '1; lin_order = 1'b1; oe_n = 1'b0; sleep = 1'b0; wdata = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R12 reset drive", {{(DW-1){1'b0}}, rdata_oe}, '0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R12 post-reset drive", {{(DW-1){1'b0}}, rdata_oe}, '0);
    idle(3, "R12");
  endtask

  task automatic t_fill();
    b_lin = 1'b1;
    for (int g = 0; g < DEPTH / 4; g++) begin
      cyc(1, 1, 0, AW'(g * 4), '0, 0, "R2");
      for (int k = 0; k < 3; k++) cyc(0, 0, 1, AW'($urandom), '0, 0, "R5");
    end
    idle(2, "R2");
  endtask

  task automatic t_readback();
    b_lin = 1'b0;
    for (int g = 0; g < DEPTH / 4; g++) begin
      cyc(1, 1, 1, AW'(g * 4 + (g % 4)), '1, 0, "R1");
      for (int k = 0; k < 4; k++) cyc(0, 0, 0, AW'($urandom), '1, 0, "R6");
    end
    b_lin = 1'b1;
    for (int g = 0; g < 8; g++) begin
      cyc(1, 1, 1, AW'(g * 12 + 3), '1, 0, "R6");
      for (int k = 0; k < 4; k++) cyc(0, 1, 0, '0, '1, 0, "R6");
    end
    idle(2, "R6");
  endtask

  task automatic t_back2back();
    for (int i = 0; i < 16; i++) begin
      cyc(1, 1, 0, AW'(i * 7), '0, 0, "R3");
      cyc(1, 1, 1, AW'(i * 7), '1, 0, "R1");
    end
    idle(3, "R1");
  endtask

  task automatic t_bytes();
    cyc(1, 1, 0, 8'd40, 4'b1010, 0, "R2");
    cyc(1, 1, 0, 8'd41, 4'b0110, 0, "R2");
    cyc(1, 1, 0, 8'd42, 4'b1111, 0, "R8");
    cyc(0, 0, 1, '0, 4'b0111, 0, "R5");
    cyc(1, 1, 1, 8'd40, '1, 0, "R2");
    cyc(1, 1, 1, 8'd41, '1, 0, "R2");
    cyc(1, 1, 1, 8'd42, '1, 0, "R8");
    cyc(1, 1, 1, 8'd43, '1, 0, "R5");
    idle(3, "R8");
  endtask

  task automatic t_desel();
    cyc(1, 0, 1, 8'd10, '1, 0, "R4");
    cyc(0, 1, 1, 8'd11, '1, 0, "R5");
    cyc(0, 1, 0, 8'd12, '0, 0, "R5");
    cyc(1, 0, 0, 8'd13, '0, 0, "R4");
    cyc(1, 0, 0, 8'd14, '0, 0, "R4");
    cyc(1, 0, 0, 8'd15, '0, 0, "R4");
    cyc(1, 1, 1, 8'd13, '1, 0, "R4");
    cyc(1, 1, 1, 8'd14, '1, 0, "R4");
    cyc(1, 1, 1, 8'd15, '1, 0, "R4");
    idle(3, "R4");
  endtask

  task automatic t_stall();
    cyc(1, 1, 1, 8'd9, '1, 0, "R7");
    cyc(1, 1, 0, 8'd9, 4'b0000, 0, "R7");
    cyc(1, 0, 0, '0, '1, 0, "R7");
    cyc(1, 0, 0, '0, '1, 1, "R7");
    cyc(1, 1, 0, 8'd9, '0, 1, "R7");
    cyc(1, 0, 0, '0, '1, 1, "R7");
    cyc(1, 0, 0, '0, '1, 0, "R7");
    cyc(1, 0, 0, '0, '1, 1, "R7");
    cyc(1, 0, 0, '0, '1, 1, "R7");
    cyc(1, 1, 1, 8'd9, '1, 0, "R7");
    idle(4, "R7");
  endtask

  task automatic t_oe();
    cyc(1, 1, 1, 8'd77, '1, 0, "R9");
    cyc(1, 0, 0, '0, '1, 0, "R9");
    cyc(1, 0, 0, '0, '1, 0, "R9");
    #1 oe_n = 1'b1;
    #0.5 chk("R9 oe high", {{(DW-1){1'b0}}, rdata_oe}, '0);
    oe_n = 1'b0;
    #0.5 chk("R9 oe low", {{(DW-1){1'b0}}, rdata_oe}, {{(DW-1){1'b0}}, 1'b1});
    chk("R9 oe data", rdata, mref[77]);
    b_oe_n = 1'b1;
    cyc(1, 1, 1, 8'd78, '1, 0, "R8");
    cyc(1, 1, 1, 8'd79, '1, 0, "R8");
    cyc(1, 0, 0, '0, '1, 0, "R8");
    cyc(1, 0, 0, '0, '1, 0, "R8");
    b_oe_n = 1'b0;
    idle(2, "R8");
  endtask

  task automatic t_sleep();
    idle(3, "R10");
    b_sleep = 1'b1;
    idle(2, "R10");
    for (int i = 0; i < 4; i++) cyc(1, 1, 0, 8'd20, '0, 0, "R10");
    cyc(1, 1, 1, 8'd20, '1, 0, "R10");
    idle(3, "R10");
    b_sleep = 1'b0;
    cyc(1, 0, 0, '0, '1, 0, "R11");
    cyc(1, 1, 1, 8'd20, '1, 0, "R11");
    cyc(1, 1, 0, 8'd21, '0, 0, "R11");
    cyc(1, 1, 1, 8'd20, '1, 0, "R10");
    cyc(1, 1, 1, 8'd21, '1, 0, "R11");
    idle(3, "R11");
  endtask

  task automatic t_random();
    for (int i = 0; i < 3000; i++) begin
      if (i % 64 == 0) b_lin = 1'($urandom);
      b_oe_n = ($urandom % 10) == 0;
      cyc(($urandom % 10) < 7, ($urandom % 10) < 8, 1'($urandom), AW'($urandom),
          (($urandom % 6) == 0) ? '1 : NB'($urandom), ($urandom % 7) == 0, "R1");
    end
    b_oe_n = 1'b0;
    idle(3, "R2");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_fill();
    t_readback();
    t_back2back();
    t_bytes();
    t_desel();
    t_stall();
    t_oe();
    t_sleep();
    t_random();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule